// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Core

This block is a small field-configurable logic device. Eleven dedicated input pins and the feedback from ten output cells together form the literals of an AND plane. Each output cell owns nine product terms. Eight of them are ORed into the cell's data sum, and the ninth may serve as the cell's output enable. Each cell then either passes the sum straight through or captures it in a flip-flop on the rising clock edge. Each cell also selects its output polarity and chooses whether its enable comes from the shared active-low enable pin or from its own enable term. With these choices, one core can stand in for a wide range of fixed-function programmable array parts.

The configuration is held in a row-addressed store that is written only while `prog_mode` is high. While `prog_mode` is high, every output driver is turned off. Each row holds one product term, and one additional row holds the per-cell architecture bits and a security flag. A bulk erase command returns every cell to its unprogrammed state. Once the security flag is set, readback returns zeros until the next erase. A preload port loads an arbitrary pattern into all cell flip-flops on a clock edge, which lets a state machine be tested from any starting state.

Top module: `pld_core`

## Requirements
- R1: Each product-term row holds two bits per literal. Bit 2i connects literal i true, and bit 2i+1 connects it complemented. Literals 0..N_IN-1 are `din`, and literal N_IN+k is the feedback of cell k. A literal with both bits set forces its term to 0. A term with no bit set evaluates to 1.
- R2: An erase, issued while `prog_mode` is high, sets every term bit to 1, so every term evaluates to 0. It sets every cell's architecture to external enable, registered, active low ({ext_oe,comb,act_high} = 3'b100). It clears the security flag.
- R3: A cell's data sum is the OR of its terms 0..7. When act_high is 1 the pin shows the sum (or the register) as is; when act_high is 0 it is inverted.
- R4: When comb is 0, the cell's register loads the sum on each rising edge of `clk`, and the pin shows the register.
- R5: Feedback is taken from the cell's register when comb is 0 and from its pad input `io_in[k]` when comb is 1.
- R6: When ext_oe is 1, `io_oe[k]` is the inverse of `ext_oe_n`. When ext_oe is 0, `io_oe[k]` follows term 8 of the cell.
- R7: While `prog_mode` is high, all `io_oe` bits are 0. Writes and erases are ignored while `prog_mode` is low.
- R8: Row cell*9+term holds a product term. Row 90 (N_CELL*9) holds the architecture word: bits 3k+2..3k carry {ext_oe,comb,act_high} of cell k, and bit 30 (3*N_CELL) is the security flag. `cfg_rdata` returns the addressed row.
- R9: While the security flag is set, `cfg_rdata` is all zeros. Writes cannot clear the flag; only an erase can.
- R10: When `pl_en` is high at a rising edge, every cell register loads its `pl_data` bit, taking precedence over the sum.
- R11: A low `rst_n` clears every cell register at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock shared by all cells |
| rst_n | input | 1 | Asynchronous active-low register reset |
| din | input | N_IN | Dedicated array inputs |
| ext_oe_n | input | 1 | Shared active-low output enable pin |
| io_in | input | N_CELL | Pad values seen by the cells |
| io_out | output | N_CELL | Cell output values |
| io_oe | output | N_CELL | Cell output driver enables |
| prog_mode | input | 1 | Configuration mode; disables all drivers |
| cfg_we | input | 1 | Row write strobe |
| cfg_erase | input | 1 | Bulk erase strobe |
| cfg_addr | input | ADDR_W | Row address |
| cfg_wdata | input | 2*(N_IN+N_CELL) | Row write data |
| cfg_rdata | output | 2*(N_IN+N_CELL) | Row readback data |
| pl_en | input | 1 | Preload strobe |
| pl_data | input | N_CELL | Preload pattern |

## Verification
The bench builds the core with its defaults: eleven dedicated inputs, ten cells and eight data terms per cell. This gives 90 term rows and a 42-bit row, which leaves room for the 31-bit architecture word. With these values, a single program holds both combinational and registered cells, both enable sources, both polarities, pad feedback and register feedback at the same time. That makes it possible to observe cross-cell feedback, preload, security and erase without reconfiguring between patterns.

// File: rtl/pldcore_pkg.sv
package pldcore_pkg;
   typedef struct packed {
      logic ext_oe;
      logic comb;
      logic act_high;
   } pld_arch_t;

   localparam pld_arch_t ARCH_ERASED = '{ext_oe: 1'b1, comb: 1'b0, act_high: 1'b0};
endpackage

// File: rtl/pld_cfg_store.sv
module pld_cfg_store
   import pldcore_pkg::*;
#(
   parameter int N_IN   = 11,
   parameter int N_CELL = 10,
   parameter int N_PT   = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   prog_mode,
   input  logic                                   cfg_we,
   input  logic                                   cfg_erase,
   input  logic [$clog2(N_CELL*(N_PT+1)+1)-1:0]   cfg_addr,
   input  logic [2*(N_IN+N_CELL)-1:0]             cfg_wdata,
   output logic [2*(N_IN+N_CELL)-1:0]             cfg_rdata,
   output logic [N_CELL*(N_PT+1)*2*(N_IN+N_CELL)-1:0] fuse_flat,
   output logic [3*N_CELL-1:0]                    arch_flat
);
   localparam int N_LIT   = N_IN + N_CELL;
   localparam int ROW_W   = 2 * N_LIT;
   localparam int N_TROWS = N_CELL * (N_PT + 1);
   localparam int ADDR_W  = $clog2(N_TROWS + 1);
   localparam logic [ADDR_W-1:0] ARCH_ADDR = ADDR_W'(N_TROWS);

   initial assert (ROW_W >= 3 * N_CELL + 1)
      else $error("row too narrow for architecture word");

   logic [ROW_W-1:0]    mem [N_TROWS];
   logic [3*N_CELL-1:0] arch_q;
   logic                sec_q;
   logic [ROW_W-1:0]    raw_rd;

   always_ff @(posedge clk) begin
      if (prog_mode) begin
         if (cfg_erase) begin
            for (int r = 0; r < N_TROWS; r++) mem[r] <= '1;
            arch_q <= {N_CELL{ARCH_ERASED}};
            sec_q  <= 1'b0;
         end else if (cfg_we) begin
            if (cfg_addr == ARCH_ADDR) begin
               arch_q <= cfg_wdata[3*N_CELL-1:0];
               sec_q  <= sec_q | cfg_wdata[3*N_CELL];
            end else if (cfg_addr < ARCH_ADDR) begin
               mem[cfg_addr] <= cfg_wdata;
            end
         end
      end
   end

   always_comb begin
      raw_rd = '0;
      if (cfg_addr == ARCH_ADDR)     raw_rd = ROW_W'({sec_q, arch_q});
      else if (cfg_addr < ARCH_ADDR) raw_rd = mem[cfg_addr];
   end

   assign cfg_rdata = sec_q ? '0 : raw_rd;
   assign arch_flat = arch_q;

   for (genvar r = 0; r < N_TROWS; r++) begin : g_flat
      assign fuse_flat[r*ROW_W +: ROW_W] = mem[r];
   end

   AST_SECURE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      sec_q |-> cfg_rdata == '0); // R9
   AST_SECURE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sec_q) && !$past(prog_mode && cfg_erase) |-> sec_q); // R9
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(prog_mode) |-> $stable(arch_q) && $stable(sec_q)); // R7
endmodule

// File: rtl/pld_and_plane.sv
module pld_and_plane #(
   parameter int N_LIT  = 21,
   parameter int N_ROWS = 90
) (
   input  logic [N_ROWS*2*N_LIT-1:0] fuse_flat,
   input  logic [N_LIT-1:0]          lits,
   output logic [N_ROWS-1:0]         pterm
);
   localparam int ROW_W = 2 * N_LIT;

   function automatic logic eval_term(input logic [ROW_W-1:0] row,
                                      input logic [N_LIT-1:0] x);
      logic acc;
      acc = 1'b1;
      for (int i = 0; i < N_LIT; i++) begin
         acc &= (~row[2*i]   |  x[i]);
         acc &= (~row[2*i+1] | ~x[i]);
      end
      return acc;
   endfunction

   for (genvar r = 0; r < N_ROWS; r++) begin : g_term
      assign pterm[r] = eval_term(fuse_flat[r*ROW_W +: ROW_W], lits);
   end
endmodule

// File: rtl/pld_cell.sv
module pld_cell
   import pldcore_pkg::*;
#(
   parameter int N_PT = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N_PT:0] pt,
   input  pld_arch_t     arch,
   input  logic          ext_oe_n,
   input  logic          prog_mode,
   input  logic          pl_en,
   input  logic          pl_d,
   input  logic          pad_in,
   output logic          pin_o,
   output logic          oe_o,
   output logic          fb_o
);
   logic sum, q, core_val;

   assign sum = |pt[N_PT-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (pl_en) q <= pl_d;
      else            q <= sum;
   end

   assign core_val = arch.comb ? sum : q;
   assign pin_o    = arch.act_high ? core_val : ~core_val;
   assign oe_o     = ~prog_mode & (arch.ext_oe ? ~ext_oe_n : pt[N_PT]);
   assign fb_o     = arch.comb ? pad_in : q;

   AST_PRELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pl_en) |-> q == $past(pl_d)); // R10
endmodule

// File: rtl/pld_core.sv
module pld_core
   import pldcore_pkg::*;
#(
   parameter int N_IN   = 11,
   parameter int N_CELL = 10,
   parameter int N_PT   = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [N_IN-1:0]                      din,
   input  logic                                 ext_oe_n,
   input  logic [N_CELL-1:0]                    io_in,
   output logic [N_CELL-1:0]                    io_out,
   output logic [N_CELL-1:0]                    io_oe,
   input  logic                                 prog_mode,
   input  logic                                 cfg_we,
   input  logic                                 cfg_erase,
   input  logic [$clog2(N_CELL*(N_PT+1)+1)-1:0] cfg_addr,
   input  logic [2*(N_IN+N_CELL)-1:0]           cfg_wdata,
   output logic [2*(N_IN+N_CELL)-1:0]           cfg_rdata,
   input  logic                                 pl_en,
   input  logic [N_CELL-1:0]                    pl_data
);
   localparam int N_LIT   = N_IN + N_CELL;
   localparam int ROW_W   = 2 * N_LIT;
   localparam int TPC     = N_PT + 1;
   localparam int N_TROWS = N_CELL * TPC;

   initial assert (N_IN > 0 && N_CELL > 0 && N_PT > 0)
      else $error("sizes must be positive");

   logic [N_TROWS*ROW_W-1:0] fuse_flat;
   logic [3*N_CELL-1:0]      arch_flat;
   logic [N_TROWS-1:0]       pterm;
   logic [N_CELL-1:0]        fb;
   logic [N_LIT-1:0]         lits;

   assign lits = {fb, din};

   pld_cfg_store #(.N_IN(N_IN), .N_CELL(N_CELL), .N_PT(N_PT)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog_mode (prog_mode),
      .cfg_we    (cfg_we),
      .cfg_erase (cfg_erase),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .fuse_flat (fuse_flat),
      .arch_flat (arch_flat)
   );

   pld_and_plane #(.N_LIT(N_LIT), .N_ROWS(N_TROWS)) u_plane (
      .fuse_flat (fuse_flat),
      .lits      (lits),
      .pterm     (pterm)
   );

   for (genvar k = 0; k < N_CELL; k++) begin : g_cell
      pld_cell #(.N_PT(N_PT)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .pt        (pterm[k*TPC +: TPC]),
         .arch      (pld_arch_t'(arch_flat[3*k +: 3])),
         .ext_oe_n  (ext_oe_n),
         .prog_mode (prog_mode),
         .pl_en     (pl_en),
         .pl_d      (pl_data[k]),
         .pad_in    (io_in[k]),
         .pin_o     (io_out[k]),
         .oe_o      (io_oe[k]),
         .fb_o      (fb[k])
      );
   end

   AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      prog_mode |-> io_oe == '0); // R7
endmodule

// File: tb/pld_core_tb.sv
module pld_core_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N_IN = 11, N_CELL = 10, N_PT = 8;
   localparam int ROW_W = 2 * (N_IN + N_CELL);
   localparam int AW = 7;
   localparam logic [AW-1:0] ARCH_ROW = 7'd90;

   logic clk = 0, rst_n = 0, ext_oe_n = 0, prog_mode = 1;
   logic cfg_we = 0, cfg_erase = 0, pl_en = 0;
   logic [N_IN-1:0]   din = '0;
   logic [N_CELL-1:0] io_in = '0, pl_data = '0, io_out, io_oe;
   logic [AW-1:0]     cfg_addr = '0;
   logic [ROW_W-1:0]  cfg_wdata = '0, cfg_rdata;
   int checks = 0, errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pld_core #(.N_IN(N_IN), .N_CELL(N_CELL), .N_PT(N_PT)) u_dut (
      .clk(clk), .rst_n(rst_n), .din(din), .ext_oe_n(ext_oe_n), .io_in(io_in),
      .io_out(io_out), .io_oe(io_oe), .prog_mode(prog_mode), .cfg_we(cfg_we),
      .cfg_erase(cfg_erase), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .pl_en(pl_en), .pl_data(pl_data));

   // vector: {din[10:0], io_in[1], exp out0, exp out1, exp oe1, exp out5}
   localparam logic [15:0] VEC [8] = '{
      {11'h000, 1'b0, 4'b1100}, {11'h007, 1'b0, 4'b1100},
      {11'h005, 1'b0, 4'b0100}, {11'h00C, 1'b0, 4'b0000},
      {11'h014, 1'b0, 4'b0110}, {11'h01F, 1'b1, 4'b1011},
      {11'h006, 1'b1, 4'b0101}, {11'h018, 1'b0, 4'b1010}};

   function automatic logic [ROW_W-1:0] lt(int i); return ROW_W'(1) << (2*i);   endfunction
   function automatic logic [ROW_W-1:0] lc(int i); return ROW_W'(1) << (2*i+1); endfunction
   function automatic logic [AW-1:0] ra(int c, int t); return AW'(c*9 + t); endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [ROW_W-1:0] d);
      @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic erase();
      @(negedge clk); cfg_erase = 1;
      @(negedge clk); cfg_erase = 0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [ROW_W-1:0] v);
      cfg_addr = a; #1; v = cfg_rdata;
   endtask

   logic [29:0] arch_prog, arch_dflt;
   logic [ROW_W-1:0] rv;

   initial begin
      arch_prog = {4{3'b100}} & 12'hFFF;
      arch_prog = {arch_prog[11:0], 3'd7, 3'd7, 3'b100, 3'b101, 3'b010, 3'b111};
      arch_dflt = {10{3'b100}};
      repeat (2) @(negedge clk);
      erase();
      wr(ra(0,0), lt(0) | lt(1));
      wr(ra(0,1), lc(2));
      wr(ra(1,0), lt(3));
      wr(ra(1,8), lt(4));
      wr(ra(2,0), lt(5));
      wr(ra(3,0), '0);
      wr(ra(4,0), lt(N_IN+2));
      wr(ra(5,0), lt(N_IN+1));
      wr(ARCH_ROW, ROW_W'({1'b0, arch_prog}));
      #1 chk("R7 prog mode drivers off", 64'(io_oe), 64'h0);
      rd(ra(2,0), rv); chk("R8 readback term row", 64'(rv), 64'(lt(5)));
      rd(ARCH_ROW, rv); chk("R8 readback arch row", 64'(rv), 64'(arch_prog));
      @(negedge clk); prog_mode = 0;
      @(negedge clk); rst_n = 1; #1;
      chk("R11 reset regs active-high", 64'(io_out[2]), 64'h0);
      chk("R11 reset regs active-low", 64'(io_out[3]), 64'h1);
      chk("R11 reset erased cell", 64'(io_out[9]), 64'h1);

      for (int v = 0; v < 8; v++) begin
         @(negedge clk); din = VEC[v][15:5]; io_in[1] = VEC[v][4]; #1;
         chk("R3 sum and polarity cell0", 64'(io_out[0]), 64'(VEC[v][3]));
         chk("R3 active-low cell1", 64'(io_out[1]), 64'(VEC[v][2]));
         chk("R6 term enable cell1", 64'(io_oe[1]), 64'(VEC[v][1]));
         chk("R5 pad feedback cell5", 64'(io_out[5]), 64'(VEC[v][0]));
         chk("R6 pin enable cell0", 64'(io_oe[0]), 64'h1);
      end

      @(negedge clk); din = 11'h020;
      @(negedge clk); #1;
      chk("R4 register captures", 64'(io_out[2]), 64'h1);
      chk("R5 register feedback", 64'(io_out[4]), 64'h1);
      chk("R1 empty term is one", 64'(io_out[3]), 64'h0);

      @(negedge clk); din = '0; pl_data = 10'h20C; pl_en = 1;
      @(negedge clk); pl_en = 0; #1;
      chk("R10 preload cell2", 64'(io_out[2]), 64'h1);
      chk("R10 preload cell3", 64'(io_out[3]), 64'h0);
      chk("R10 preload cell9", 64'(io_out[9]), 64'h0);
      @(negedge clk); #1;
      chk("R4 normal capture after preload", 64'(io_out[2]), 64'h0);
      chk("R4 erased cell recaptures", 64'(io_out[9]), 64'h1);

      ext_oe_n = 1; din = 11'h010; #1;
      chk("R6 pin disable cell0", 64'(io_oe[0]), 64'h0);
      chk("R6 pin disable cell2", 64'(io_oe[2]), 64'h0);
      chk("R6 term enable indep", 64'(io_oe[1]), 64'h1);
      ext_oe_n = 0; din = '0;

      wr(ra(0,0), '0);
      rd(ra(0,0), rv); chk("R7 write ignored", 64'(rv), 64'(lt(0) | lt(1)));
      #1 chk("R7 function unchanged", 64'(io_out[0]), 64'h1);

      @(negedge clk); din = 11'h020;
      @(negedge clk); #2 rst_n = 0; #1;
      chk("R11 async reset", 64'(io_out[2]), 64'h0);
      @(negedge clk); rst_n = 1; din = '0;

      prog_mode = 1;
      wr(ARCH_ROW, ROW_W'({1'b1, arch_prog}));
      rd(ra(0,0), rv); chk("R9 secure term blank", 64'(rv), 64'h0);
      rd(ARCH_ROW, rv); chk("R9 secure arch blank", 64'(rv), 64'h0);
      wr(ARCH_ROW, ROW_W'({1'b0, arch_prog}));
      rd(ARCH_ROW, rv); chk("R9 security sticky", 64'(rv), 64'h0);
      erase();
      rd(ra(0,0), rv); chk("R2 erased term row", 64'(rv), 64'({ROW_W{1'b1}}));
      rd(ARCH_ROW, rv); chk("R2 erased arch row", 64'(rv), 64'(arch_dflt));
      @(negedge clk); prog_mode = 0;
      @(negedge clk); @(negedge clk); #1;
      chk("R2 erased outputs", 64'(io_out), 64'h3FF);
      chk("R2 erased enables", 64'(io_oe), 64'h3FF);

      prog_mode = 1; wr(ra(0,0), lt(0) | lc(0)); prog_mode = 0;
      @(negedge clk); @(negedge clk); #1;
      chk("R1 both connected is zero", 64'(io_out[0]), 64'h1);
      prog_mode = 1; wr(ra(0,0), '0); prog_mode = 0;
      @(negedge clk); @(negedge clk); #1;
      chk("R1 none connected is one", 64'(io_out[0]), 64'h0);

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule